// File: doc/BRIEF.md
# Bit Test-and-Invert Execution Unit

This unit runs one single-bit change instruction for a 32-bit processor datapath. It takes a 16-bit opcode word. For the immediate form it also takes a 16-bit extension word that carries the bit number. In the register form the bit number comes from a data register. The unit reads the destination, which is either a data register or a memory byte. It reports whether the chosen bit was zero in the Z flag and writes the operand back with that bit inverted. Address generation and bus cycles stay outside the unit. Memory bytes move over a simple request/acknowledge pair, and register values come from the surrounding register file.

A single state machine drives the work through these states:

- `ST_IDLE` accepts an opcode. A matching opcode with an illegal destination goes to `ST_BAD`. A legal immediate form goes to `ST_EXT`. A legal register form goes to `ST_OPER`. A non-matching opcode leaves the unit in `ST_IDLE`.
- `ST_EXT` waits for the extension handshake and then goes to `ST_OPER`.
- `ST_OPER` handles a register destination by writing the register and the flags, then goes to `ST_FIN`. For a memory destination it latches the bit number and goes to `ST_RDB`.
- `ST_RDB` holds the byte read request until it is acknowledged, then goes to `ST_WRB`.
- `ST_WRB` holds the write request until it is acknowledged, updating the flags on that cycle, then goes to `ST_FIN`.
- `ST_FIN` raises `done` and returns to `ST_IDLE`.
- `ST_BAD` raises `illegal` and returns to `ST_IDLE`.

Top module: `bitflip_unit`

## Requirements
- R1: The register form is recognised when opcode bits 15..12 are 0000 and bits 8..6 are 101. Its bit number is the value of the data register named by opcode bits 11..9, which appears on `src_reg_idx`.
- R2: The immediate form is recognised when opcode bits 15..6 equal 0000100001. The unit waits with `ext_ready` high for as many cycles as the extension word takes. It writes nothing before that word arrives. Only the low byte of the extension word gives the bit number, and the upper byte has no effect.
- R3: When the destination mode (opcode bits 5..3) is 000, the destination is the data register named by opcode bits 2..0. The bit index is the bit number modulo 32, with bit 0 the least significant. `reg_wr_data` equals the old register value with exactly that bit inverted, and `reg_wr_en` pulses once.
- R4: For a memory destination the unit issues one byte read. It then issues one byte write whose data is the read byte with bit (bit number modulo 8) inverted. No register is written.
- R5: The flags word is ordered X,N,Z,V,C from bit 4 down to bit 0. On the single `flags_we` pulse, Z (bit 2) is 1 if the tested bit was 0 before the change and 0 if it was 1.
- R6: On `flags_we`, bits 4, 3, 1 and 0 of `flags_out` equal those of `flags_in`.
- R7: Legal destinations are mode 000, modes 010 through 110 with any register, and mode 111 with register 000 or 001. Any other destination on a matching opcode gives a one-cycle `illegal` pulse in the cycle after acceptance. It causes no extension fetch, no register, memory or flag write and no `done`, and `op_ready` is high again one cycle later.
- R8: An opcode matching neither form is consumed with no response: no `illegal`, `done`, `ext_ready`, memory request or write of any kind.
- R9: `done` pulses for one cycle in the cycle after the register write (register destination) or in the cycle after the memory write is accepted (memory destination).
- R10: After reset `op_ready` is 1 and `ext_ready`, `reg_wr_en`, `mem_rd_req`, `mem_wr_req`, `flags_we`, `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode word offered |
| op_word | input | 16 | Opcode word |
| op_ready | output | 1 | Unit idle; opcode taken when op_valid is high |
| ext_valid | input | 1 | Extension word offered |
| ext_word | input | 16 | Extension word holding the bit number in its low byte |
| ext_ready | output | 1 | Unit waiting for the extension word |
| src_reg_idx | output | 3 | Data register holding the bit number |
| src_reg_data | input | 32 | Value of register src_reg_idx |
| dst_reg_idx | output | 3 | Destination data register index |
| dst_reg_data | input | 32 | Value of register dst_reg_idx |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | 32 | Modified register value |
| mem_rd_req | output | 1 | Byte read request |
| mem_rd_ack | input | 1 | Byte read acknowledge with data |
| mem_rd_data | input | 8 | Byte read data |
| mem_wr_req | output | 1 | Byte write request |
| mem_wr_ack | input | 1 | Byte write acknowledge |
| mem_wr_data | output | 8 | Modified byte |
| flags_in | input | 5 | Current flags X,N,Z,V,C (bit 4..0) |
| flags_out | output | 5 | Updated flags |
| flags_we | output | 1 | Flags write strobe |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Illegal destination reported |

## Verification
A state register that strays or sticks shows up at the handshake ports within a cycle or two. In that case `op_ready` stays low, `ext_ready` rises for a register-form opcode, a memory request appears for a register destination, or `done` arrives one cycle early or late relative to the write acceptance. A wrong latched bit number or memory byte shows on the very write that ends the operation: the written data then differs from the old value in some bit other than the selected one, or in more than one bit, and Z disagrees with that bit. The sweeps cover all 256 extension bit numbers, 64 register bit numbers and every legal memory mode, so a modulo or index error shows up in the first operation that uses an affected value.

// File: rtl/bitflip_pkg.sv
package bitflip_pkg;

    localparam int OPW    = 16;
    localparam int FLAG_W = 5;
    localparam int FLG_Z  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_OPER,
        ST_RDB,
        ST_WRB,
        ST_FIN,
        ST_BAD
    } bf_state_e;

    typedef struct packed {
        logic hit;
        logic imm;
        logic legal;
        logic dst_reg;
    } bf_dec_t;

endpackage

// File: rtl/bitflip_decode.sv
module bitflip_decode
    import bitflip_pkg::*;
(
    input  logic [OPW-1:0] op,
    output bf_dec_t        dec
);

    logic       reg_form;
    logic       imm_form;
    logic [2:0] mode;
    logic [2:0] rn;
    logic       legal_mode;

    assign reg_form = (op[15:12] == 4'b0000) && (op[8:6] == 3'b101);
    assign imm_form = (op[15:6] == 10'b0000100001);
    assign mode     = op[5:3];
    assign rn       = op[2:0];

    always_comb begin
        unique case (mode)
            3'b000:  legal_mode = 1'b1;
            3'b001:  legal_mode = 1'b0;
            3'b111:  legal_mode = (rn == 3'b000) || (rn == 3'b001);
            default: legal_mode = 1'b1;
        endcase
    end

    assign dec.hit     = reg_form || imm_form;
    assign dec.imm     = imm_form;
    assign dec.legal   = legal_mode;
    assign dec.dst_reg = (mode == 3'b000);

endmodule

// File: rtl/bitflip_flip.sv
module bitflip_flip #(
    parameter int W    = 32,
    parameter int BN_W = 32
) (
    input  logic [W-1:0]    opnd,
    input  logic [BN_W-1:0] bitnum,
    output logic [W-1:0]    result,
    output logic            was_zero
);

    localparam int IW = $clog2(W);

    logic [IW-1:0] idx;
    logic [W-1:0]  mask;

    assign idx      = IW'(bitnum % BN_W'(W));
    assign mask     = W'(1) << idx;
    assign was_zero = ~|(opnd & mask);
    assign result   = opnd ^ mask;

endmodule

// File: rtl/bitflip_unit.sv
module bitflip_unit
    import bitflip_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [15:0]       op_word,
    output logic              op_ready,
    input  logic              ext_valid,
    input  logic [15:0]       ext_word,
    output logic              ext_ready,
    output logic [2:0]        src_reg_idx,
    input  logic [DATA_W-1:0] src_reg_data,
    output logic [2:0]        dst_reg_idx,
    input  logic [DATA_W-1:0] dst_reg_data,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              mem_rd_req,
    input  logic              mem_rd_ack,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    input  logic              mem_wr_ack,
    output logic [BYTE_W-1:0] mem_wr_data,
    input  logic [4:0]        flags_in,
    output logic [4:0]        flags_out,
    output logic              flags_we,
    output logic              done,
    output logic              illegal
);

    localparam int PAD_W = DATA_W - OPW;

    bf_state_e          st_q;
    bf_state_e          st_d;
    logic [OPW-1:0]     op_q;
    logic [OPW-1:0]     dec_in;
    bf_dec_t            dec;
    logic [DATA_W-1:0]  bnum_q;
    logic [DATA_W-1:0]  bnum_eff;
    logic [BYTE_W-1:0]  byte_q;
    logic [DATA_W-1:0]  reg_res;
    logic               reg_zero;
    logic [BYTE_W-1:0]  byte_res;
    logic               byte_zero;

    assign dec_in = (st_q == ST_IDLE) ? op_word : op_q;

    bitflip_decode u_dec (
        .op  (dec_in),
        .dec (dec)
    );

    assign bnum_eff = dec.imm ? bnum_q : src_reg_data;

    bitflip_flip #(.W(DATA_W), .BN_W(DATA_W)) u_flip_reg (
        .opnd     (dst_reg_data),
        .bitnum   (bnum_eff),
        .result   (reg_res),
        .was_zero (reg_zero)
    );

    bitflip_flip #(.W(BYTE_W), .BN_W(DATA_W)) u_flip_byte (
        .opnd     (byte_q),
        .bitnum   (bnum_q),
        .result   (byte_res),
        .was_zero (byte_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (op_valid && dec.hit) begin
                    if (!dec.legal) begin
                        st_d = ST_BAD;
                    end else if (dec.imm) begin
                        st_d = ST_EXT;
                    end else begin
                        st_d = ST_OPER;
                    end
                end
            end
            ST_EXT:  if (ext_valid) st_d = ST_OPER;
            ST_OPER: st_d = dec.dst_reg ? ST_FIN : ST_RDB;
            ST_RDB:  if (mem_rd_ack) st_d = ST_WRB;
            ST_WRB:  if (mem_wr_ack) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            ST_BAD:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // datapath holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            bnum_q <= '0;
            byte_q <= '0;
        end else begin
            if (st_q == ST_IDLE && op_valid) begin
                op_q <= op_word;
            end
            if (st_q == ST_EXT && ext_valid) begin
                bnum_q <= {{PAD_W{1'b0}}, ext_word};
            end else if (st_q == ST_OPER && !dec.imm) begin
                bnum_q <= src_reg_data;
            end
            if (st_q == ST_RDB && mem_rd_ack) begin
                byte_q <= mem_rd_data;
            end
        end
    end

    assign src_reg_idx = op_q[11:9];
    assign dst_reg_idx = op_q[2:0];
    assign reg_wr_data = reg_res;
    assign mem_wr_data = byte_res;

    // outputs
    always_comb begin
        op_ready   = 1'b0;
        ext_ready  = 1'b0;
        reg_wr_en  = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        flags_we   = 1'b0;
        done       = 1'b0;
        illegal    = 1'b0;
        flags_out  = flags_in;
        unique case (st_q)
            ST_IDLE: op_ready = 1'b1;
            ST_EXT:  ext_ready = 1'b1;
            ST_OPER: begin
                if (dec.dst_reg) begin
                    reg_wr_en        = 1'b1;
                    flags_we         = 1'b1;
                    flags_out[FLG_Z] = reg_zero;
                end
            end
            ST_RDB:  mem_rd_req = 1'b1;
            ST_WRB: begin
                mem_wr_req       = 1'b1;
                flags_we         = mem_wr_ack;
                flags_out[FLG_Z] = byte_zero;
            end
            ST_FIN:  done = 1'b1;
            ST_BAD:  illegal = 1'b1;
            default: op_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/bitflip_unit_chk.sv
module bitflip_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_ready,
    input logic        ext_ready,
    input logic [31:0] dst_reg_data,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic        mem_rd_req,
    input logic        mem_wr_req,
    input logic        mem_wr_ack,
    input logic [7:0]  mem_wr_data,
    input logic [4:0]  flags_in,
    input logic [4:0]  flags_out,
    input logic        flags_we,
    input logic        done,
    input logic        illegal
);

    // R3
    single_bit_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $countones(reg_wr_data ^ dst_reg_data) == 1);

    // R6
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[4:3] == flags_in[4:3]) && (flags_out[1:0] == flags_in[1:0]));

    // R9
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ack) |=> done);

    // R9
    done_after_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> done);

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req && $stable(mem_wr_data));

    // R7
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> op_ready && !flags_we && !reg_wr_en);

    // R7
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_ready, ext_ready, mem_rd_req, mem_wr_req, done, illegal}));

endmodule

bind bitflip_unit bitflip_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_ready     (op_ready),
    .ext_ready    (ext_ready),
    .dst_reg_data (dst_reg_data),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .mem_rd_req   (mem_rd_req),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_ack   (mem_wr_ack),
    .mem_wr_data  (mem_wr_data),
    .flags_in     (flags_in),
    .flags_out    (flags_out),
    .flags_we     (flags_we),
    .done         (done),
    .illegal      (illegal)
);

// File: tb/bitflip_unit_tb_top.sv
module bitflip_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_word = '0;
    logic        op_ready;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        ext_ready;
    logic [2:0]  src_reg_idx;
    logic [31:0] src_reg_data;
    logic [2:0]  dst_reg_idx;
    logic [31:0] dst_reg_data;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic        mem_rd_req;
    logic        mem_rd_ack;
    logic [7:0]  mem_rd_data = '0;
    logic        mem_wr_req;
    logic        mem_wr_ack;
    logic [7:0]  mem_wr_data;
    logic [4:0]  flags_in = '0;
    logic [4:0]  flags_out;
    logic        flags_we;
    logic        done;
    logic        illegal;

    logic [31:0] regs [8];
    logic        rd_gate = 1'b0;
    logic        wr_gate = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int rf_cnt, fl_cnt, rd_cnt, wr_cnt, done_cnt, ill_cnt, extr_cnt;
    int wr_cyc, done_cyc, early;
    logic [31:0] rf_wd;
    logic [2:0]  rf_widx;
    logic [4:0]  fl_v;
    logic [7:0]  wr_d;

    always #5 clk = ~clk;

    assign src_reg_data = regs[src_reg_idx];
    assign dst_reg_data = regs[dst_reg_idx];
    assign mem_rd_ack   = mem_rd_req & rd_gate;
    assign mem_wr_ack   = mem_wr_req & wr_gate;

    bitflip_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_word      (op_word),
        .op_ready     (op_ready),
        .ext_valid    (ext_valid),
        .ext_word     (ext_word),
        .ext_ready    (ext_ready),
        .src_reg_idx  (src_reg_idx),
        .src_reg_data (src_reg_data),
        .dst_reg_idx  (dst_reg_idx),
        .dst_reg_data (dst_reg_data),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_ack   (mem_rd_ack),
        .mem_rd_data  (mem_rd_data),
        .mem_wr_req   (mem_wr_req),
        .mem_wr_ack   (mem_wr_ack),
        .mem_wr_data  (mem_wr_data),
        .flags_in     (flags_in),
        .flags_out    (flags_out),
        .flags_we     (flags_we),
        .done         (done),
        .illegal      (illegal)
    );

    // memory responder: acknowledge one cycle after a request appears
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_gate <= mem_rd_req;
        wr_gate <= mem_wr_req;
    end

    // port monitor
    always @(negedge clk) begin
        if (reg_wr_en) begin rf_cnt++; rf_wd = reg_wr_data; rf_widx = dst_reg_idx; end
        if (flags_we) begin fl_cnt++; fl_v = flags_out; end
        if (mem_rd_req && mem_rd_ack) rd_cnt++;
        if (mem_wr_req && mem_wr_ack) begin wr_cnt++; wr_d = mem_wr_data; wr_cyc = cyc; end
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (illegal) ill_cnt++;
        if (ext_ready) extr_cnt++;
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp<=150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        rf_cnt = 0; fl_cnt = 0; rd_cnt = 0; wr_cnt = 0;
        done_cnt = 0; ill_cnt = 0; extr_cnt = 0; early = 0;
        wr_cyc = -1; done_cyc = -2;
    endtask

    task automatic issue(input logic [15:0] op, input bit use_ext, input logic [15:0] ext,
                         input int ext_delay, input bit expect_end);
        clr();
        @(negedge clk);
        op_word  = op;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (use_ext) begin
            for (int k = 0; k < ext_delay; k++) @(negedge clk);
            early    = rf_cnt + rd_cnt + wr_cnt + done_cnt + fl_cnt;
            ext_word = ext;
            ext_valid = 1'b1;
            @(negedge clk);
            ext_valid = 1'b0;
        end
        if (expect_end) begin
            for (int k = 0; k < 16 && done_cnt == 0 && ill_cnt == 0; k++) @(negedge clk);
            @(negedge clk);
        end else begin
            for (int k = 0; k < 8; k++) @(negedge clk);
        end
    endtask

    function automatic logic [15:0] op_reg(input logic [2:0] src, input logic [2:0] md, input logic [2:0] rn);
        return {4'b0000, src, 3'b101, md, rn};
    endfunction

    function automatic logic [15:0] op_imm(input logic [2:0] md, input logic [2:0] rn);
        return {10'b0000100001, md, rn};
    endfunction

    task automatic run_reg(input bit imm, input logic [2:0] src, input logic [2:0] dst,
                           input logic [15:0] ext, input int dly);
        logic [31:0] old;
        logic [31:0] bn;
        int          pos;
        logic [31:0] expv;
        logic [4:0]  fexp;
        old  = regs[dst];
        bn   = imm ? {24'h0, ext[7:0]} : regs[src];
        pos  = int'(bn % 32);
        expv = old ^ (32'h1 << pos);
        fexp = {flags_in[4:3], ~old[pos], flags_in[1:0]};
        if (imm) issue(op_imm(3'b000, dst), 1'b1, ext, dly, 1'b1);
        else     issue(op_reg(src, 3'b000, dst), 1'b0, 16'h0, 0, 1'b1);
        // R3 register write value and target
        chk(rf_cnt == 1 && rf_wd == expv && rf_widx == dst, imm ? "R3/R2" : "R3/R1", rf_wd, expv);
        // R5 R6 flags
        chk(fl_cnt == 1 && fl_v == fexp, "R5/R6", {27'h0, fl_v}, {27'h0, fexp});
        // R9 single done, no memory activity
        chk(done_cnt == 1 && rd_cnt == 0 && wr_cnt == 0 && ill_cnt == 0, "R9",
            done_cnt, 1);
        if (imm) begin
            // R2 nothing written while waiting
            chk(early == 0 && extr_cnt == dly + 1, "R2", extr_cnt, dly + 1);
        end else begin
            // R1 no extension wait for register form
            chk(extr_cnt == 0, "R1", extr_cnt, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h1111_1111 * i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(op_ready && !ext_ready && !reg_wr_en && !mem_rd_req && !mem_wr_req &&
            !flags_we && !done && !illegal, "R10",
            {24'h0, op_ready, ext_ready, reg_wr_en, mem_rd_req, mem_wr_req, flags_we, done, illegal},
            32'h80);

        // register form, register destination: bit numbers 0..63
        for (int b = 0; b < 64; b++) begin
            regs[2] = {24'h5A5A5A ^ 24'(b * 7), 8'(b)};
            regs[5] = (b % 2 == 0) ? 32'hA5A5_0F0F : 32'h5A5A_F0F0;
            flags_in = 5'(b);
            run_reg(1'b0, 3'd2, 3'd5, 16'h0, 0);
        end
        // register form, same register as source and destination
        for (int b = 0; b < 8; b++) begin
            regs[1] = 32'hFFFF_FF00 | 32'(b * 5);
            flags_in = 5'(~b);
            run_reg(1'b0, 3'd1, 3'd1, 16'h0, 0);
        end
        // immediate form, register destination: all 256 bit numbers, garbage upper byte
        for (int b = 0; b < 256; b++) begin
            for (int i = 0; i < 8; i++) regs[i] = 32'h9E37_79B9 * (b + i + 1);
            flags_in = 5'(b * 3);
            run_reg(1'b1, 3'd0, 3'(b % 8), {8'(b) ^ 8'h3C, 8'(b)}, b % 4);
        end

        // memory destinations over every legal mode
        for (int m = 0; m < 7; m++) begin
            for (int b = 0; b < 16; b++) begin
                logic [2:0]  md;
                logic [2:0]  rn;
                logic        imm;
                logic [31:0] bn;
                logic [7:0]  mb;
                logic [7:0]  expb;
                logic [4:0]  fexp;
                int          pos;
                md  = (m < 5) ? 3'(m + 2) : 3'b111;
                rn  = (m < 5) ? 3'(b % 8) : 3'(m - 5);
                imm = (b % 2 == 0);
                regs[6] = 32'(b) + 32'h40 * 32'(m);
                bn  = imm ? 32'(b) : regs[6];
                mb  = 8'h96 ^ 8'(b * 13 + m);
                pos = int'(bn % 8);
                expb = mb ^ (8'h1 << pos);
                fexp = {flags_in[4:3], ~mb[pos], flags_in[1:0]};
                mem_rd_data = mb;
                flags_in = 5'(b + m);
                fexp = {flags_in[4:3], ~mb[pos], flags_in[1:0]};
                if (imm) issue(op_imm(md, rn), 1'b1, {8'hC3, 8'(b)}, 1, 1'b1);
                else     issue(op_reg(3'd6, md, rn), 1'b0, 16'h0, 0, 1'b1);
                // R4 one read, one write of modified byte, no register write
                chk(rd_cnt == 1 && wr_cnt == 1 && rf_cnt == 0 && wr_d == expb, "R4",
                    {24'h0, wr_d}, {24'h0, expb});
                // R5 R6 flags on memory path
                chk(fl_cnt == 1 && fl_v == fexp, "R5/R6", {27'h0, fl_v}, {27'h0, fexp});
                // R9 done one cycle after write acceptance
                chk(done_cnt == 1 && done_cyc == wr_cyc + 1, "R9", done_cyc, wr_cyc + 1);
            end
        end

        // illegal destinations
        begin
            logic [15:0] bad_ops [8];
            bad_ops[0] = op_reg(3'd0, 3'b001, 3'd0);
            bad_ops[1] = op_reg(3'd3, 3'b001, 3'd7);
            bad_ops[2] = op_reg(3'd1, 3'b111, 3'b010);
            bad_ops[3] = op_reg(3'd1, 3'b111, 3'b100);
            bad_ops[4] = op_imm(3'b001, 3'd2);
            bad_ops[5] = op_imm(3'b111, 3'b011);
            bad_ops[6] = op_imm(3'b111, 3'b100);
            bad_ops[7] = op_imm(3'b111, 3'b111);
            for (int i = 0; i < 8; i++) begin
                issue(bad_ops[i], 1'b0, 16'h0, 0, 1'b1);
                // R7 illegal pulse only, back to idle
                chk(ill_cnt == 1 && done_cnt == 0 && rf_cnt == 0 && fl_cnt == 0 &&
                    rd_cnt == 0 && wr_cnt == 0 && extr_cnt == 0 && op_ready, "R7",
                    {bad_ops[i], 8'(ill_cnt), 8'(rf_cnt + fl_cnt + rd_cnt + wr_cnt + extr_cnt)},
                    {bad_ops[i], 8'h1, 8'h0});
            end
        end

        // non-matching opcodes
        begin
            logic [15:0] nm [5];
            nm[0] = 16'h0180;
            nm[1] = 16'h0800;
            nm[2] = 16'h1140;
            nm[3] = 16'h08C0;
            nm[4] = 16'h0100;
            for (int i = 0; i < 5; i++) begin
                issue(nm[i], 1'b0, 16'h0, 0, 1'b0);
                // R8 no response
                chk(ill_cnt == 0 && done_cnt == 0 && rf_cnt == 0 && fl_cnt == 0 &&
                    rd_cnt == 0 && wr_cnt == 0 && extr_cnt == 0 && op_ready, "R8",
                    {nm[i], 16'(ill_cnt + done_cnt + rf_cnt + fl_cnt + rd_cnt + wr_cnt + extr_cnt)},
                    {nm[i], 16'h0});
            end
        end

        // a legal operation still works after the ignored ones
        regs[4] = 32'h0000_0000;
        regs[7] = 32'd31;
        flags_in = 5'b11011;
        run_reg(1'b0, 3'd7, 3'd4, 16'h0, 0);

        finish_run();
    end

endmodule